// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small register-based processor core. It holds a control address register that selects one word of an internal microinstruction store. Each word drives the datapath: register file, RAM, program counter, instruction register, ALU and five routing multiplexers. The store is indexed by the control address alone. The instruction being executed affects control flow at exactly one point: a decode step jumps through a table that maps the opcode to the first word of that instruction's routine.

An instruction runs as follows. Microaddress 0 fetches it: the instruction register loads, the program counter advances, and the control address steps to 1. Microaddress 1 decodes it by jumping through the dispatch table. The routine then runs for one or two steps, and its last word sends the control address back to 0. The next control address is chosen by a multiplexer from three sources: the current address plus one, zero, or the dispatch table entry. The program counter write enable is not stored as a plain bit. It is formed from an unconditional load bit and two branch flags, each qualified by the ALU zero flag. The block's inputs are the instruction opcode field and the ALU zero flag. Its outputs are the control signals. The datapath registers themselves are outside the block.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `car` is 0. The outputs then show the fetch word. A reset in the middle of an instruction abandons that instruction.
- R2: At `car` 0, `ir_load` and `pc_write` are 1, `mux_sel` is 00000 (the PC takes PC+1), `ram_read`, `ram_write` and `reg_write` are 0, and the next `car` is 1.
- R3: At `car` 1, every write or read enable is 0, `mux_sel` is 00000, and the next `car` is the dispatch table entry for `opcode`.
- R4: Opcode bits [4:3] give the class and bits [2:0] the subcode. Class 00 with subcode 000..101 (add, sub, and, or, decode, set-less-than) runs one step. That step has `alu_op` equal to the subcode, `reg_write` 1, and `mux_sel` 00000 (write data from the ALU).
- R5: Opcode 00111 (load immediate) runs one step with `reg_write` 1 and `mux_sel` 00100 (write data from the instruction's value field).
- R6: Opcode 01000 (load) runs two steps. Step 1 has `ram_read` 1 and `mux_sel` 10000 (RAM address from the instruction). Step 2 has `ram_read` 1, `reg_write` 1, and `mux_sel` 10010 (write data from RAM).
- R7: Opcode 01001 (store) runs two steps, both with `mux_sel` 11000 (register read port A addressed by the instruction's register field, RAM address from the instruction). Only step 2 has `ram_write` 1.
- R8: Opcode 10000 (jump) runs one step with `pc_write` 1 for either value of `alu_zero`, and `mux_sel` 00001 (the PC takes the target field).
- R9: Opcode 10001 (branch if not equal) runs one step with `alu_op` 001 and `mux_sel` 00001. In that step `pc_write` equals NOT `alu_zero`.
- R10: Opcode 10010 (branch if equal) runs one step with `alu_op` 001 and `mux_sel` 00001. In that step `pc_write` equals `alu_zero`.
- R11: Any other opcode has a dispatch entry of 0. It runs no step: the cycle after decode is a fetch, and no enable is raised.
- R12: Every routine's last step returns `car` to 0, so an instruction of n steps takes n+2 cycles. During the routine's own steps `car` is above 1.
- R13: `ram_read` and `ram_write` are never 1 together, nor are `reg_write` and `ram_write`. Outside the fetch step, `pc_write` is 1 only when `mux_sel` bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 5 | Opcode field of the instruction register, class in [4:3] |
| alu_zero | input | 1 | ALU result-is-zero flag |
| car | output | 5 | Current control address |
| alu_op | output | 3 | ALU operation code |
| pc_write | output | 1 | Program counter write enable |
| ir_load | output | 1 | Instruction register load enable |
| ram_read | output | 1 | RAM read enable |
| ram_write | output | 1 | RAM write enable |
| reg_write | output | 1 | Register file write enable |
| mux_sel | output | 5 | Datapath multiplexer selects, bit meanings as in R2 to R10 |

## Verification
The zero flag is driven both ways through every step, not only during the branch steps. A gating term that lets a branch flag leak into ordinary steps would then raise a stray PC write. A branch with its condition inverted fails on one of the two flag values. Opcodes next to the mapped ones (subcode 110, class 11, memory subcode 010) go through decode. A table that does not default to zero would start a routine for them, or hang away from fetch. Two-step routines are checked one step at a time, and the return to address 0 is checked at each following fetch. A routine that returns one step early or late would shift every later comparison. A reset asserted in the middle of a load must bring the sequencer back to the fetch word.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W  = 5;
    localparam int ALU_W  = 3;
    localparam int NMUX   = 5;

    // datapath mux select bit positions
    localparam int MX_PC_TGT  = 0;
    localparam int MX_WB_MEM  = 1;
    localparam int MX_WB_IMM  = 2;
    localparam int MX_RDA_DST = 3;
    localparam int MX_ADDR_IR = 4;

    // microaddress layout
    localparam int UA_FETCH  = 0;
    localparam int UA_DECODE = 1;
    localparam int UA_ALU    = 2;
    localparam int N_ALU_OPS = 6;
    localparam int UA_LDI    = UA_ALU + N_ALU_OPS;
    localparam int UA_LD     = UA_LDI + 1;
    localparam int UA_ST     = UA_LD + 2;
    localparam int UA_J      = UA_ST + 2;
    localparam int UA_JNE    = UA_J + 1;
    localparam int UA_JE     = UA_JNE + 1;
    localparam int UA_USED   = UA_JE + 1;

    typedef enum logic [1:0] {
        CL_ALU = 2'b00,
        CL_MEM = 2'b01,
        CL_CTL = 2'b10
    } op_class_e;

    typedef enum logic [1:0] {
        NX_INC  = 2'b00,
        NX_DISP = 2'b01,
        NX_ZERO = 2'b10
    } nxt_e;

    typedef struct packed {
        logic [ALU_W-1:0] alu_op;
        logic             pc_load;
        logic             ir_load;
        logic             ram_rd;
        logic             ram_wr;
        logic             reg_wr;
        logic             br_eq;
        logic             br_ne;
        nxt_e             nxt;
        logic [NMUX-1:0]  mux;
    } uword_t;

    localparam logic [ALU_W-1:0] ALU_SUB = 3'b001;

    // opcode -> first microaddress of its routine, 0 when unmapped
    function automatic int dispatch_of(input int code);
        logic [OPC_W-1:0] o;
        int               r;
        o = OPC_W'(code);
        r = UA_FETCH;
        case (o[4:3])
            CL_ALU: begin
                if (int'(o[2:0]) < N_ALU_OPS) r = UA_ALU + int'(o[2:0]);
                else if (o[2:0] == 3'b111)    r = UA_LDI;
            end
            CL_MEM: begin
                if (o[2:0] == 3'b000)      r = UA_LD;
                else if (o[2:0] == 3'b001) r = UA_ST;
            end
            CL_CTL: begin
                case (o[2:0])
                    3'b000:  r = UA_J;
                    3'b001:  r = UA_JNE;
                    3'b010:  r = UA_JE;
                    default: r = UA_FETCH;
                endcase
            end
            default: r = UA_FETCH;
        endcase
        return r;
    endfunction

    function automatic logic [NMUX-1:0] mx(input int bit_idx);
        logic [NMUX-1:0] m;
        m = '0;
        m[bit_idx] = 1'b1;
        return m;
    endfunction

    // microinstruction store contents, computed per address
    function automatic uword_t ucode(input int a);
        uword_t w;
        w     = '0;
        w.nxt = NX_ZERO;
        if (a >= UA_ALU && a < UA_ALU + N_ALU_OPS) begin
            w.alu_op = ALU_W'(a - UA_ALU);
            w.reg_wr = 1'b1;
        end else begin
            case (a)
                UA_FETCH: begin
                    w.ir_load = 1'b1;
                    w.pc_load = 1'b1;
                    w.nxt     = NX_INC;
                end
                UA_DECODE: w.nxt = NX_DISP;
                UA_LDI: begin
                    w.reg_wr = 1'b1;
                    w.mux    = mx(MX_WB_IMM);
                end
                UA_LD: begin
                    w.ram_rd = 1'b1;
                    w.mux    = mx(MX_ADDR_IR);
                    w.nxt    = NX_INC;
                end
                UA_LD + 1: begin
                    w.ram_rd = 1'b1;
                    w.reg_wr = 1'b1;
                    w.mux    = mx(MX_ADDR_IR) | mx(MX_WB_MEM);
                end
                UA_ST: begin
                    w.mux = mx(MX_ADDR_IR) | mx(MX_RDA_DST);
                    w.nxt = NX_INC;
                end
                UA_ST + 1: begin
                    w.ram_wr = 1'b1;
                    w.mux    = mx(MX_ADDR_IR) | mx(MX_RDA_DST);
                end
                UA_J: begin
                    w.pc_load = 1'b1;
                    w.mux     = mx(MX_PC_TGT);
                end
                UA_JNE: begin
                    w.alu_op = ALU_SUB;
                    w.br_ne  = 1'b1;
                    w.mux    = mx(MX_PC_TGT);
                end
                UA_JE: begin
                    w.alu_op = ALU_SUB;
                    w.br_eq  = 1'b1;
                    w.mux    = mx(MX_PC_TGT);
                end
                default: w.nxt = NX_ZERO;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_car.sv
module useq_car
    import useq_pkg::*;
#(
    parameter int CAR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  nxt_e             sel,
    input  logic [CAR_W-1:0] disp_addr,
    output logic [CAR_W-1:0] car
);
    logic [CAR_W-1:0] car_next;

    always_comb begin
        case (sel)
            NX_INC:  car_next = car + CAR_W'(1);
            NX_DISP: car_next = disp_addr;
            default: car_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) car <= '0;
        else     car <= car_next;
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OPC_BITS = 5,
    parameter int CAR_W    = 5
) (
    input  logic [OPC_BITS-1:0] opcode,
    output logic [CAR_W-1:0]    disp_addr
);
    localparam int N_OPC = 1 << OPC_BITS;

    logic [CAR_W-1:0] table_q [N_OPC];

    for (genvar i = 0; i < N_OPC; i++) begin : g_tbl
        assign table_q[i] = CAR_W'(dispatch_of(i));
    end

    assign disp_addr = table_q[opcode];
endmodule

// File: rtl/useq_urom.sv
module useq_urom
    import useq_pkg::*;
#(
    parameter int CAR_W = 5
) (
    input  logic [CAR_W-1:0] addr,
    output uword_t           word
);
    localparam int DEPTH = 1 << CAR_W;

    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = ucode(i);
    end

    assign word = rom[addr];
endmodule

// File: rtl/useq_pcgate.sv
module useq_pcgate (
    input  logic pc_load,
    input  logic br_eq,
    input  logic br_ne,
    input  logic zero,
    output logic pc_write
);
    assign pc_write = pc_load | (br_eq & zero) | (br_ne & ~zero);
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int CAR_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [OPC_W-1:0]       opcode,
    input  logic                   alu_zero,
    output logic [CAR_W-1:0]       car,
    output logic [ALU_W-1:0]       alu_op,
    output logic                   pc_write,
    output logic                   ir_load,
    output logic                   ram_read,
    output logic                   ram_write,
    output logic                   reg_write,
    output logic [NMUX-1:0]        mux_sel
);
    uword_t           uw;
    logic [CAR_W-1:0] disp_addr;

    useq_car #(.CAR_W(CAR_W)) u_car (
        .clk       (clk),
        .rst       (rst),
        .sel       (uw.nxt),
        .disp_addr (disp_addr),
        .car       (car)
    );

    useq_dispatch #(.OPC_BITS(OPC_W), .CAR_W(CAR_W)) u_disp (
        .opcode    (opcode),
        .disp_addr (disp_addr)
    );

    useq_urom #(.CAR_W(CAR_W)) u_rom (
        .addr (car),
        .word (uw)
    );

    useq_pcgate u_pcg (
        .pc_load  (uw.pc_load),
        .br_eq    (uw.br_eq),
        .br_ne    (uw.br_ne),
        .zero     (alu_zero),
        .pc_write (pc_write)
    );

    assign alu_op    = uw.alu_op;
    assign ir_load   = uw.ir_load;
    assign ram_read  = uw.ram_rd;
    assign ram_write = uw.ram_wr;
    assign reg_write = uw.reg_wr;
    assign mux_sel   = uw.mux;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
#(
    parameter int CAR_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [OPC_W-1:0] opcode,
    input logic [CAR_W-1:0] car,
    input logic             pc_write,
    input logic             ir_load,
    input logic             ram_read,
    input logic             ram_write,
    input logic             reg_write,
    input logic [NMUX-1:0]  mux_sel
);
    AST_RESET_CAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> car == '0); // R1
    AST_FETCH_WRITES: assert property (@(posedge clk) disable iff (rst)
        car == '0 |-> (ir_load && pc_write && !reg_write && !ram_write)); // R2
    AST_FETCH_NEXT: assert property (@(posedge clk) disable iff (rst)
        car == '0 |=> car == CAR_W'(1)); // R2
    AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        car == CAR_W'(1) |-> !(ir_load || pc_write || ram_read || ram_write || reg_write)); // R3
    AST_UNMAPPED_SKIP: assert property (@(posedge clk) disable iff (rst)
        (car == CAR_W'(1) && dispatch_of(int'(opcode)) == 0) |=> car == '0); // R11
    AST_IRLOAD_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
        ir_load |-> car == '0); // R12
    AST_RAM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ram_read && ram_write)); // R13
    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(reg_write && ram_write)); // R13
    AST_PC_TARGET: assert property (@(posedge clk) disable iff (rst)
        (pc_write && car != '0) |-> mux_sel[MX_PC_TGT]); // R13
endmodule

bind useq_ctrl useq_ctrl_chk #(.CAR_W(CAR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .car       (car),
    .pc_write  (pc_write),
    .ir_load   (ir_load),
    .ram_read  (ram_read),
    .ram_write (ram_write),
    .reg_write (reg_write),
    .mux_sel   (mux_sel)
);

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] opcode = '0;
    logic       alu_zero = 1'b0;
    logic [4:0] car;
    logic [2:0] alu_op;
    logic       pc_write, ir_load, ram_read, ram_write, reg_write;
    logic [4:0] mux_sel;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    useq_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .car(car), .alu_op(alu_op), .pc_write(pc_write), .ir_load(ir_load),
        .ram_read(ram_read), .ram_write(ram_write), .reg_write(reg_write),
        .mux_sel(mux_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int       alu;   // -1 = not checked
        bit       pcw, irl, rr, rw, rgw;
        bit [4:0] mux;
    } exp_t;

    function automatic int n_steps(input bit [4:0] op);
        if (op[4:3] == 2'b00 && op[2:0] <= 3'd5) return 1;
        if (op == 5'b00111) return 1;
        if (op == 5'b01000 || op == 5'b01001) return 2;
        if (op == 5'b10000 || op == 5'b10001 || op == 5'b10010) return 1;
        return 0;
    endfunction

    function automatic exp_t exp_step(input bit [4:0] op, input int k, input bit z);
        exp_t e = '{alu: -1, pcw: 0, irl: 0, rr: 0, rw: 0, rgw: 0, mux: 5'b00000};
        if (op[4:3] == 2'b00 && op[2:0] <= 3'd5) begin
            e.alu = int'(op[2:0]); e.rgw = 1;
        end else if (op == 5'b00111) begin
            e.rgw = 1; e.mux = 5'b00100;
        end else if (op == 5'b01000) begin
            e.rr = 1;
            if (k == 0) e.mux = 5'b10000;
            else begin e.rgw = 1; e.mux = 5'b10010; end
        end else if (op == 5'b01001) begin
            e.mux = 5'b11000; e.rw = (k == 1);
        end else if (op == 5'b10000) begin
            e.pcw = 1; e.mux = 5'b00001;
        end else if (op == 5'b10001) begin
            e.alu = 1; e.pcw = !z; e.mux = 5'b00001;
        end else if (op == 5'b10010) begin
            e.alu = 1; e.pcw = z; e.mux = 5'b00001;
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmp(input exp_t e, input string req);
        if (e.alu >= 0) chk(int'(alu_op) == e.alu, req, "alu_op", int'(alu_op), e.alu);
        chk(pc_write == e.pcw,  req, "pc_write",  int'(pc_write),  int'(e.pcw));
        chk(ir_load == e.irl,   req, "ir_load",   int'(ir_load),   int'(e.irl));
        chk(ram_read == e.rr,   req, "ram_read",  int'(ram_read),  int'(e.rr));
        chk(ram_write == e.rw,  req, "ram_write", int'(ram_write), int'(e.rw));
        chk(reg_write == e.rgw, req, "reg_write", int'(reg_write), int'(e.rgw));
        chk(mux_sel == e.mux,   req, "mux_sel",   int'(mux_sel),   int'(e.mux));
    endtask

    function automatic exp_t fetch_exp();
        return '{alu: -1, pcw: 1, irl: 1, rr: 0, rw: 0, rgw: 0, mux: 5'b00000};
    endfunction

    // called at a negedge in the fetch cycle; returns at the negedge of the next fetch
    task automatic run_instr(input bit [4:0] op, input bit z, input string req);
        int n = n_steps(op);
        opcode = op;
        alu_zero = z;
        #1;
        chk(car == 5'd0, "R12", "fetch car", int'(car), 0);
        cmp(fetch_exp(), "R2");
        @(posedge clk); @(negedge clk);
        chk(car == 5'd1, "R2", "decode car", int'(car), 1);
        cmp('{alu: -1, pcw: 0, irl: 0, rr: 0, rw: 0, rgw: 0, mux: 5'b00000}, "R3");
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
            chk(car > 5'd1, "R12", "step car", int'(car), 2);
            cmp(exp_step(op, k, z), req);
            alu_zero = !z;
            #1;
            cmp(exp_step(op, k, !z), req);
            alu_zero = z;
        end
        @(posedge clk); @(negedge clk);
        if (n == 0) chk(car == 5'd0, "R11", "car after unmapped decode", int'(car), 0);
        else        chk(car == 5'd0, "R12", "car after routine", int'(car), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(car == 5'd0, "R1", "car in reset", int'(car), 0);
        cmp(fetch_exp(), "R1");
        rst = 1'b0;
        @(negedge clk);
        // back at fetch? no: one edge passed, car now 1
        chk(car == 5'd1, "R1", "car after first fetch", int'(car), 1);
        @(posedge clk); @(negedge clk);   // opcode 0 -> add routine
        @(posedge clk); @(negedge clk);
        chk(car == 5'd0, "R1", "car at second fetch", int'(car), 0);

        for (int s = 0; s < 6; s++) begin
            run_instr(5'(s), 1'b1, "R4");
            run_instr(5'(s), 1'b0, "R4");
        end
        run_instr(5'b00111, 1'b1, "R5");
        run_instr(5'b01000, 1'b0, "R6");
        run_instr(5'b01000, 1'b1, "R6");
        run_instr(5'b01001, 1'b0, "R7");
        run_instr(5'b01001, 1'b1, "R7");
        run_instr(5'b10000, 1'b0, "R8");
        run_instr(5'b10000, 1'b1, "R8");
        run_instr(5'b10001, 1'b0, "R9");
        run_instr(5'b10001, 1'b1, "R9");
        run_instr(5'b10010, 1'b0, "R10");
        run_instr(5'b10010, 1'b1, "R10");
        run_instr(5'b00110, 1'b1, "R11");
        run_instr(5'b01010, 1'b0, "R11");
        run_instr(5'b11000, 1'b1, "R11");
        run_instr(5'b10011, 1'b0, "R11");
        run_instr(5'b11111, 1'b1, "R11");
        run_instr(5'b00010, 1'b0, "R4");

        // reset in the middle of a load (R1)
        opcode = 5'b01000;
        @(posedge clk); @(negedge clk);   // decode
        @(posedge clk); @(negedge clk);   // load step 1
        chk(ram_read == 1'b1, "R6", "ram_read before reset", int'(ram_read), 1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(car == 5'd0, "R1", "car after mid-routine reset", int'(car), 0);
        cmp(fetch_exp(), "R1");
        rst = 1'b0;
        @(negedge clk);
        chk(car == 5'd1, "R1", "car resumes at decode", int'(car), 1);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        run_instr(5'b10001, 1'b0, "R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule